// File: doc/BRIEF.md
# Non-cacheable region decoder

This block decides, for any 32-bit physical address, whether that address is non-cacheable. A cache controller presents the address on `probe_addr` and reads the answer on `nc_hit`. Two sources feed the answer. The first is a set of programmable regions, each described by a base address and a power-of-two size code. The second is a pair of fixed legacy windows, each switched on by a bit in a control byte.

Software programs the block through a byte-wide register port with 8-bit register addresses. Each region uses three adjacent byte registers, and each of those bytes is written on its own. Reading returns the current contents of any defined register without delay. With the `HIT_REG` parameter the hit can be taken straight from the compare logic, or registered so that it arrives one cycle after the address.

Top module: `nc_region_decoder`

## Requirements
- R1: After a synchronous active-low reset, every register reads back as 0x00 and `nc_hit` is 0 for every address.
- R2: Region i (i = 0..3) owns the register addresses 0xC4+3i, 0xC5+3i and 0xC6+3i. The first byte holds base bits 31..24 and the second holds base bits 23..16. The third byte holds base bits 15..12 in bits 7..4 and the size code in bits 3..0. Each byte reads back exactly as it was written.
- R3: A write changes only the single byte it addresses. The other bytes of the same region keep their values.
- R4: A region whose size code is 0 never matches.
- R5: A size code s from 1 to 14 makes the region cover 2^(11+s) bytes, from 4 KB up to 32 MB, starting at its base. The address one below the base misses, and so does the address one past the last byte.
- R6: Size code 15 makes the region match every 32-bit address.
- R7: Base bits that lie below the region size are ignored, so a misaligned base selects the aligned block that contains it.
- R8: While bit 0 of the control byte at 0xC0 is set, every address whose bits 19..16 are zero is non-cacheable, which is the first 64 KB of each 1 MB.
- R9: While bit 1 of the control byte at 0xC0 is set, addresses 0x000A_0000 through 0x000F_FFFF are non-cacheable.
- R10: The byte at 0xC0 stores and returns all 8 bits. The byte at 0xC1 stores only bit 0, and its bits 7..1 read as zero.
- R11: A read of any other register address returns 0x00. A write to any other address changes no register and no hit result.
- R12: `nc_hit` is the OR of all region matches and both enabled windows. Overlapping regions are allowed, and removing one of them leaves the rest of the overlap in effect.
- R13: With `HIT_REG`=1, `nc_hit` shows the hit result for the address and register contents present one cycle earlier, and it is 0 in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register address for both read and write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte, combinational from `reg_addr` |
| probe_addr | input | 32 | Physical address to classify |
| nc_hit | output | 1 | 1 when `probe_addr` is non-cacheable |

## Verification
A wrong stored byte shows on `reg_rdata` in the very cycle that address is read back. It also shows on `nc_hit` as soon as a probe lands near the edge of the affected region. A fault in the mask or size decode shows only at block boundaries, so the probes cover the first byte and the last byte of each region, and the address one step outside it at each end. A fault in the output register shows one cycle late. For that reason the registered copy is compared on every cycle against the expected result from the cycle before.

// File: rtl/nc_dec_pkg.sv
// Package: shared constants and the per-region configuration layout for the
// non-cacheable region decoder. Assumes 8-bit register addresses.
package nc_dec_pkg;
    localparam int unsigned PROBE_W          = 32;
    localparam int unsigned BYTES_PER_REGION = 3;
    localparam logic [7:0]  CTRL0_ADDR       = 8'hC0;
    localparam logic [7:0]  CTRL1_ADDR       = 8'hC1;
    localparam logic [3:0]  SIZE_NONE        = 4'd0;
    localparam logic [3:0]  SIZE_ALL         = 4'd15;
    localparam logic [4:0]  SIZE_SHIFT_BIAS  = 5'd11;

    // Field order matches the three bytes of a region, most significant first.
    typedef struct packed {
        logic [7:0] base_hi;
        logic [7:0] base_mid;
        logic [3:0] base_lo;
        logic [3:0] size_code;
    } region_cfg_t;
endpackage

// File: rtl/nc_regfile.sv
// Module: byte-wide configuration storage with combinational readback.
// Assumes REGION_BASE + 3*NUM_REGIONS <= 256 and no overlap with the two
// control addresses. Undefined addresses read as zero and ignore writes.
module nc_regfile
    import nc_dec_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned REGION_BASE = 32'hC4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [7:0]                          addr,
    input  logic [7:0]                          wdata,
    output logic [7:0]                          rdata,
    output logic [7:0]                          ctrl0_o,
    output logic                                ctrl1_o,
    output region_cfg_t [NUM_REGIONS-1:0]       cfg_o
);
    localparam int unsigned NUM_BYTES = NUM_REGIONS * BYTES_PER_REGION;

    logic [NUM_BYTES-1:0][7:0] bytes_q;
    logic [7:0]                ctrl0_q;
    logic                      ctrl1_q;
    logic [31:0]               addr_w;

    assign addr_w = {24'd0, addr};

    // Purpose: capture single-byte writes into the addressed register only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
            ctrl0_q <= '0;
            ctrl1_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == CTRL0_ADDR) ctrl0_q <= wdata;
            if (addr == CTRL1_ADDR) ctrl1_q <= wdata[0];
            for (int j = 0; j < NUM_BYTES; j++) begin
                if (addr_w == 32'(REGION_BASE + j)) bytes_q[j] <= wdata;
            end
        end
    end

    // Purpose: return the byte at the current address, zero when undefined.
    always_comb begin
        rdata = 8'h00;
        if (addr == CTRL0_ADDR) rdata = ctrl0_q;
        if (addr == CTRL1_ADDR) rdata = {7'd0, ctrl1_q};
        for (int j = 0; j < NUM_BYTES; j++) begin
            if (addr_w == 32'(REGION_BASE + j)) rdata = bytes_q[j];
        end
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cfg
        assign cfg_o[i] = {bytes_q[3*i], bytes_q[3*i+1], bytes_q[3*i+2]};
    end

    assign ctrl0_o = ctrl0_q;
    assign ctrl1_o = ctrl1_q;
endmodule

// File: rtl/nc_region_match.sv
// Module: compares one probe address against one programmable region.
// Assumes size code 1..14 spans 2^(11+code) bytes; base bits under the
// region size are masked out, so a misaligned base still behaves sensibly.
module nc_region_match
    import nc_dec_pkg::*;
(
    input  region_cfg_t          cfg_i,
    input  logic [PROBE_W-1:0]   probe_i,
    output logic                 hit_o
);
    logic [PROBE_W-1:0] base;
    logic [PROBE_W-1:0] mask;
    logic [4:0]         shamt;

    // Purpose: build the compare mask from the size code and test the probe.
    always_comb begin
        base  = {cfg_i.base_hi, cfg_i.base_mid, cfg_i.base_lo, 12'h000};
        shamt = SIZE_SHIFT_BIAS + {1'b0, cfg_i.size_code};
        if (cfg_i.size_code == SIZE_ALL) mask = '0;
        else                             mask = {PROBE_W{1'b1}} << shamt;
        hit_o = (cfg_i.size_code != SIZE_NONE) && (((probe_i ^ base) & mask) == '0);
    end
endmodule

// File: rtl/nc_legacy_windows.sv
// Module: the two fixed non-cacheable windows. Takes probe bits 31..16 only,
// since both windows are aligned to 64 KB.
module nc_legacy_windows (
    input  logic        en_low64k_i,
    input  logic        en_video_i,
    input  logic [15:0] probe_hi_i,
    output logic        hit_low64k_o,
    output logic        hit_video_o
);
    localparam logic [15:0] VIDEO_START = 16'h000A;
    localparam logic [15:0] VIDEO_END   = 16'h0010;

    // Purpose: decode the first-64K-of-each-megabyte and 640K..1M windows.
    always_comb begin
        hit_low64k_o = en_low64k_i && (probe_hi_i[3:0] == 4'h0);
        hit_video_o  = en_video_i && (probe_hi_i >= VIDEO_START) && (probe_hi_i < VIDEO_END);
    end
endmodule

// File: rtl/nc_region_decoder.sv
// Module: top of the non-cacheable region decoder. Combines the register
// bank, one matcher per region and the fixed windows. HIT_REG=1 registers
// the hit, adding one cycle of latency; HIT_REG=0 leaves it combinational.
module nc_region_decoder
    import nc_dec_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned REGION_BASE = 32'hC4,
    parameter bit          HIT_REG     = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [7:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [31:0]        probe_addr,
    output logic               nc_hit
);
    region_cfg_t [NUM_REGIONS-1:0] cfg;
    logic [NUM_REGIONS-1:0]        region_match;
    logic [NUM_REGIONS-1:0][3:0]   region_size;
    logic [7:0]                    ctrl0;
    logic                          ctrl1;
    logic                          hit_low64k;
    logic                          hit_video;
    logic                          hit_comb;

    nc_regfile #(
        .NUM_REGIONS (NUM_REGIONS),
        .REGION_BASE (REGION_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .ctrl0_o (ctrl0),
        .ctrl1_o (ctrl1),
        .cfg_o   (cfg)
    );

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        nc_region_match u_match (
            .cfg_i   (cfg[i]),
            .probe_i (probe_addr),
            .hit_o   (region_match[i])
        );
        assign region_size[i] = cfg[i].size_code;
    end

    nc_legacy_windows u_legacy (
        .en_low64k_i  (ctrl0[0]),
        .en_video_i   (ctrl0[1]),
        .probe_hi_i   (probe_addr[31:16]),
        .hit_low64k_o (hit_low64k),
        .hit_video_o  (hit_video)
    );

    assign hit_comb = (|region_match) | hit_low64k | hit_video;

    if (HIT_REG) begin : g_hit_reg
        logic hit_q;
        // Purpose: delay the hit by one cycle for timing-critical consumers.
        always_ff @(posedge clk) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= hit_comb;
        end
        assign nc_hit = hit_q;
    end else begin : g_hit_comb
        assign nc_hit = hit_comb;
    end

    // ctrl1 has no function in this block beyond storage and readback.
    logic unused_ctrl;
    assign unused_ctrl = ctrl1 ^ (^ctrl0[7:2]);
endmodule

// File: rtl/nc_region_decoder_chk.sv
// Checker: temporal properties of the decoder, bound to every instance.
module nc_region_decoder_chk #(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned REGION_BASE = 32'hC4,
    parameter bit          HIT_REG     = 1'b0
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [7:0]                   reg_addr,
    input logic [7:0]                   reg_rdata,
    input logic [31:0]                  probe_addr,
    input logic                         nc_hit,
    input logic                         hit_comb,
    input logic [NUM_REGIONS-1:0]       region_match,
    input logic [NUM_REGIONS-1:0][3:0]  region_size,
    input logic [7:0]                   ctrl0
);
    logic [31:0] addr_w;
    logic        addr_defined;
    assign addr_w       = {24'd0, reg_addr};
    assign addr_defined = (reg_addr == 8'hC0) || (reg_addr == 8'hC1) ||
                          ((addr_w >= REGION_BASE) && (addr_w < REGION_BASE + 3 * NUM_REGIONS));

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_per_region
        AST_SIZE_ZERO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
            (region_size[i] == 4'd0) |-> !region_match[i]); // R4
        AST_SIZE_FULL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (region_size[i] == 4'd15) |-> region_match[i]); // R6
    end

    AST_REGION_FEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|region_match) |-> hit_comb); // R12
    AST_LOW64K_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0[0] && probe_addr[19:16] == 4'h0) |-> hit_comb); // R8
    AST_VIDEO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0[1] && probe_addr >= 32'h000A_0000 && probe_addr <= 32'h000F_FFFF) |-> hit_comb); // R9
    AST_CTRL1_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'hC1) |-> (reg_rdata[7:1] == 7'd0)); // R10
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_defined |-> (reg_rdata == 8'h00)); // R11

    if (HIT_REG) begin : g_delay
        AST_HIT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (nc_hit == $past(hit_comb))); // R13
    end else begin : g_nodelay
        logic unused_hit;
        assign unused_hit = nc_hit;
    end
endmodule

bind nc_region_decoder nc_region_decoder_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_BASE (REGION_BASE),
    .HIT_REG     (HIT_REG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .probe_addr   (probe_addr),
    .nc_hit       (nc_hit),
    .hit_comb     (hit_comb),
    .region_match (region_match),
    .region_size  (region_size),
    .ctrl0        (ctrl0)
);

// File: tb/sim_nc_region_decoder.sv
`timescale 1ns/1ps
module sim_nc_region_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [31:0] probe_addr = 32'h0;
    logic [7:0]  rdata0, rdata1;
    logic        hit0, hit1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    int unsigned m_bytes [12];
    int unsigned m_c0 = 0;
    int unsigned m_c1 = 0;
    bit          prev_exp = 1'b0;
    string       rd_override = "";

    always #2 clk = ~clk;

    nc_region_decoder #(.HIT_REG(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata0), .probe_addr(probe_addr), .nc_hit(hit0));

    nc_region_decoder #(.HIT_REG(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata1), .probe_addr(probe_addr), .nc_hit(hit1));

    function automatic bit ref_hit(input logic [31:0] a);
        longint unsigned addr = longint'(a);
        for (int r = 0; r < 4; r++) begin
            int unsigned code = m_bytes[3*r+2] & 15;
            longint unsigned len, base;
            if (code == 0) continue;
            if (code == 15) return 1'b1;
            len  = 64'd1 << (11 + code);
            base = (longint'(m_bytes[3*r]) << 24) + (longint'(m_bytes[3*r+1]) << 16)
                 + (longint'(m_bytes[3*r+2] >> 4) << 12);
            base = base - (base % len);
            if (addr >= base && addr < base + len) return 1'b1;
        end
        if ((m_c0 & 1) != 0 && (addr % 64'h10_0000) < 64'h1_0000) return 1'b1;
        if ((m_c0 & 2) != 0 && addr >= 64'hA_0000 && addr < 64'h10_0000) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int unsigned ref_rd(input int unsigned a);
        if (a == 'hC0) return m_c0;
        if (a == 'hC1) return m_c1;
        if (a >= 'hC4 && a < 'hD0) return m_bytes[a - 'hC4];
        return 0;
    endfunction

    function automatic string rd_tag(input int unsigned a);
        if (rd_override != "") return rd_override;
        if (a == 'hC0 || a == 'hC1) return "R10";
        if (a >= 'hC4 && a < 'hD0) return "R2";
        return "R11";
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One clock: drive, compare both instances against the model, then update the model.
    task automatic cycle(input bit w, input logic [7:0] a, input logic [7:0] d,
                         input logic [31:0] p, input string tag);
        bit exp;
        @(negedge clk);
        reg_wr_en = w; reg_addr = a; reg_wdata = d; probe_addr = p;
        #1;
        exp = ref_hit(p);
        check(hit0 === exp, tag, longint'(hit0), longint'(exp));
        check(rdata0 === 8'(ref_rd(a)), rd_tag(a), longint'(rdata0), longint'(ref_rd(a)));
        check(hit1 === prev_exp, "R13", longint'(hit1), longint'(prev_exp)); // R13 registered copy
        @(posedge clk);
        prev_exp = exp;
        if (w) begin
            if (a == 8'hC0) m_c0 = d;
            else if (a == 8'hC1) m_c1 = d & 1;
            else if (a >= 8'hC4 && a < 8'hD0) m_bytes[a - 8'hC4] = d;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        cycle(1'b1, a, d, probe_addr, tag);
    endtask

    task automatic pr(input logic [31:0] p, input string tag);
        cycle(1'b0, reg_addr, 8'h00, p, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cycle(1'b0, a, 8'h00, probe_addr, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        for (int i = 0; i < 12; i++) m_bytes[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state across the whole register space and a few probes.
        rd_override = "R1";
        for (int a = 0; a < 256; a++) rd(8'(a), "R1");
        rd_override = "";
        pr(32'h0000_0000, "R1");
        pr(32'hFFFF_FFFF, "R1");
        pr(32'h000A_0000, "R1");

        // R2 / R5: region 0 at 0x8000_0000, 64 KB (code 5).
        wr(8'hC4, 8'h80, "R2");
        wr(8'hC5, 8'h00, "R2");
        wr(8'hC6, 8'h05, "R2");
        rd(8'hC4, "R2"); rd(8'hC5, "R2"); rd(8'hC6, "R2");
        pr(32'h8000_0000, "R5");
        pr(32'h8000_FFFF, "R5");
        pr(32'h8001_0000, "R5");
        pr(32'h7FFF_FFFF, "R5");

        // R3: rewrite only the top byte, the others stay.
        wr(8'hC4, 8'h90, "R3");
        rd(8'hC5, "R3"); rd(8'hC6, "R3");
        pr(32'h9000_0000, "R3");
        pr(32'h8000_0000, "R3");

        // R4 / R6: region 1 zero size then whole space.
        wr(8'hC7, 8'h10, "R4");
        wr(8'hC9, 8'h00, "R4");
        pr(32'h1000_0000, "R4");
        wr(8'hC9, 8'h0F, "R6");
        pr(32'hFFFF_FFFF, "R6");
        pr(32'h0000_0000, "R6");
        pr(32'h5555_1234, "R6");
        wr(8'hC9, 8'h00, "R4");
        pr(32'h1000_0000, "R4");

        // R7: region 2 misaligned base 0x0012_3000, 16 KB (code 3).
        wr(8'hCA, 8'h00, "R7");
        wr(8'hCB, 8'h12, "R7");
        wr(8'hCC, 8'h33, "R7");
        pr(32'h0012_0000, "R7");
        pr(32'h0012_3FFF, "R7");
        pr(32'h0012_4000, "R7");
        pr(32'h0011_FFFF, "R7");

        // R12: region 3, 32 MB (code 14), overlaps region 0.
        wr(8'hCD, 8'h90, "R12");
        wr(8'hCE, 8'h00, "R12");
        wr(8'hCF, 8'h0E, "R12");
        pr(32'h9000_8000, "R12");
        wr(8'hC6, 8'h00, "R12");
        pr(32'h9000_8000, "R12");
        pr(32'h91FF_FFFF, "R5");
        pr(32'h9200_0000, "R5");

        // R8 / R9 / R10: fixed windows and control readback.
        wr(8'hC0, 8'h01, "R8");
        pr(32'h0030_0000, "R8");
        pr(32'h0030_FFFF, "R8");
        pr(32'h0031_0000, "R8");
        pr(32'hFFF0_0010, "R8");
        wr(8'hC0, 8'h02, "R9");
        pr(32'h000A_0000, "R9");
        pr(32'h0009_FFFF, "R9");
        pr(32'h000F_FFFF, "R9");
        pr(32'h0010_0000, "R9");
        pr(32'h0030_0000, "R9");
        wr(8'hC0, 8'hFF, "R10");
        rd(8'hC0, "R10");
        pr(32'h0000_1234, "R12");
        wr(8'hC1, 8'hFF, "R10");
        rd(8'hC1, "R10");
        wr(8'hC1, 8'hFE, "R10");
        rd(8'hC1, "R10");
        wr(8'hC0, 8'h00, "R10");

        // R11: undefined addresses ignore writes and read zero.
        wr(8'hC2, 8'hFF, "R11");
        wr(8'hC3, 8'hFF, "R11");
        wr(8'hD0, 8'hFF, "R11");
        wr(8'hBF, 8'hFF, "R11");
        wr(8'h00, 8'hFF, "R11");
        for (int a = 'hBE; a < 'hD4; a++) rd(8'(a), "R11");
        pr(32'h0000_0000, "R11");
        pr(32'h9000_0000, "R11");

        // Mixed traffic: writes anywhere near the bank and biased probes.
        for (int n = 0; n < 3000; n++) begin
            int unsigned sel = $urandom % 4;
            logic [31:0] p = $urandom;
            if (sel == 0) begin
                wr(8'(8'hBE + ($urandom % 22)), 8'($urandom), "R3");
            end else begin
                if (sel == 1) p[31:24] = 8'(m_bytes[3 * ($urandom % 4)]);
                if (sel == 2) p[31:20] = 12'h000;
                pr(p, "R12");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule